// File: doc/BRIEF.md
# Burst Address Sequencer with Selectable Beat Order

This block produces the word addresses of a four-beat burst on a synchronous memory port. In a load cycle it takes a base address and a transfer direction. In each advance cycle after that it moves the two lowest address bits to the next beat, and the bits above them keep the value they had at load. After the fourth beat the pattern starts again and keeps repeating for as long as advance cycles continue.

A static order input picks one of two beat orders. Linear order counts up from the starting offset modulo four. Interleaved order XORs the starting offset with the beat number. The direction captured at load stays in force for the whole burst. The direction input is ignored in advance cycles.

A load cycle with the select input low puts the block in an idle state. A low clock enable makes the block skip the cycle, so every register keeps its value. All outputs come from registers and change on the rising clock edge after the cycle that causes the change.

Top module: `bseq_top`

## Requirements
- R1: A synchronous reset, which takes priority over the clock enable, sets `word_addr` to 0, `burst_wr` to 0 and `burst_act` to 0 one edge later.
- R2: A cycle with `clk_en`=1, `step`=0 and `sel`=1 is a load. After the edge, `word_addr` equals `base_addr`, `burst_act`=1 and `burst_wr` equals `wr_dir`.
- R3: With `interleave`=0, beat n of a burst that started at low offset s puts (s+n) mod 4 on `word_addr[1:0]`. Beat 0 is the load itself.
- R4: With `interleave`=1, beat n of a burst that started at low offset s puts s XOR (n mod 4) on `word_addr[1:0]`.
- R5: While the block advances, `word_addr[ADDR_W-1:2]` keeps the value loaded from `base_addr`.
- R6: After beat 3 the sequence wraps. Beat n and beat n+4 give the same address, and advancing continues without limit.
- R7: In advance cycles (`step`=1) `wr_dir` is ignored, and `burst_wr` keeps the value captured at load.
- R8: A cycle with `clk_en`=0 changes no output, whatever the other inputs are.
- R9: A cycle with `clk_en`=1, `step`=0 and `sel`=0 clears `burst_act` and leaves `word_addr` unchanged. Advance cycles while idle change no output.
- R10: A load while a burst is active abandons that burst and starts a new one from the new base address and offset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| clk_en | input | 1 | Cycle enable; 0 skips the cycle |
| step | input | 1 | 1 = advance the burst, 0 = load or deselect |
| sel | input | 1 | Chip select, sampled in load cycles |
| wr_dir | input | 1 | Direction for a new burst (1 = write) |
| interleave | input | 1 | Beat order: 0 = linear, 1 = interleaved |
| base_addr | input | ADDR_W | Base word address for a load |
| word_addr | output | ADDR_W | Current word address |
| burst_wr | output | 1 | Direction of the current burst |
| burst_act | output | 1 | Burst in progress |

## Verification
The bench builds the block with `ADDR_W`=6. This leaves four upper bits above the two beat bits, so every one of the 64 base addresses can be loaded in both order modes. Each of those bursts advances nine beats, which passes the wrap point twice and covers every start offset with every upper-bit pattern. Between beats the bench toggles the direction input and inserts disabled cycles. It also exercises deselect, advancing while idle, a reload in the middle of a burst and a reset in the middle of a burst.

// File: rtl/bseq_pkg.sv
package bseq_pkg;

  // Number of address bits that move inside one burst (four beats).
  localparam int unsigned OFS_W = 2;

  typedef enum logic {
    ORD_LINEAR = 1'b0,
    ORD_XOR    = 1'b1
  } order_e;

  typedef enum logic [1:0] {
    CMD_HOLD  = 2'd0,
    CMD_LOAD  = 2'd1,
    CMD_DESEL = 2'd2,
    CMD_STEP  = 2'd3
  } cmd_e;

endpackage

// File: rtl/bseq_ctrl.sv
module bseq_ctrl
  import bseq_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             clk_en,
  input  logic             step,
  input  logic             sel,
  input  logic             wr_dir,
  output cmd_e             cmd,
  output logic [OFS_W-1:0] beat_nxt,
  output logic             act_q,
  output logic             dir_q
);

  logic [OFS_W-1:0] beat_q;

  // Decode of the cycle type; advancing while idle counts as a hold.
  always_comb begin
    if (!clk_en)      cmd = CMD_HOLD;
    else if (!step)   cmd = sel ? CMD_LOAD : CMD_DESEL;
    else if (act_q)   cmd = CMD_STEP;
    else              cmd = CMD_HOLD;
  end

  assign beat_nxt = beat_q + OFS_W'(1);

  always_ff @(posedge clk) begin
    if (rst) begin
      act_q  <= 1'b0;
      dir_q  <= 1'b0;
      beat_q <= '0;
    end else begin
      unique case (cmd)
        CMD_LOAD: begin
          act_q  <= 1'b1;
          dir_q  <= wr_dir;
          beat_q <= '0;
        end
        CMD_DESEL: begin
          act_q  <= 1'b0;
          beat_q <= '0;
        end
        CMD_STEP:  beat_q <= beat_nxt;
        default:   ;
      endcase
    end
  end

endmodule

// File: rtl/bseq_order.sv
module bseq_order
  import bseq_pkg::*;
(
  input  logic [OFS_W-1:0] start,
  input  logic [OFS_W-1:0] beat,
  input  order_e           mode,
  output logic [OFS_W-1:0] ofs
);

  logic [OFS_W-1:0] lin_ofs;
  logic [OFS_W-1:0] xor_ofs;

  // Modulo-four wrap comes from the OFS_W-bit width.
  assign lin_ofs = start + beat;
  assign xor_ofs = start ^ beat;
  assign ofs     = (mode == ORD_XOR) ? xor_ofs : lin_ofs;

endmodule

// File: rtl/bseq_addr.sv
module bseq_addr
  import bseq_pkg::*;
#(
  parameter int unsigned ADDR_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  cmd_e              cmd,
  input  logic [ADDR_W-1:0] base_addr,
  input  logic [OFS_W-1:0]  ofs,
  output logic [OFS_W-1:0]  start_q,
  output logic [ADDR_W-1:0] word_q
);

  always_ff @(posedge clk) begin
    if (rst) begin
      word_q  <= '0;
      start_q <= '0;
    end else begin
      unique case (cmd)
        CMD_LOAD: begin
          word_q  <= base_addr;
          start_q <= base_addr[OFS_W-1:0];
        end
        CMD_STEP: word_q[OFS_W-1:0] <= ofs;
        default:  ;
      endcase
    end
  end

endmodule

// File: rtl/bseq_top.sv
module bseq_top
  import bseq_pkg::*;
#(
  parameter int unsigned ADDR_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clk_en,
  input  logic              step,
  input  logic              sel,
  input  logic              wr_dir,
  input  logic              interleave,
  input  logic [ADDR_W-1:0] base_addr,
  output logic [ADDR_W-1:0] word_addr,
  output logic              burst_wr,
  output logic              burst_act
);

  cmd_e             cmd;
  logic [OFS_W-1:0] beat_nxt;
  logic [OFS_W-1:0] start_q;
  logic [OFS_W-1:0] ofs;
  order_e           mode;

  assign mode = interleave ? ORD_XOR : ORD_LINEAR;

  bseq_ctrl u_ctrl (
    .clk      (clk),
    .rst      (rst),
    .clk_en   (clk_en),
    .step     (step),
    .sel      (sel),
    .wr_dir   (wr_dir),
    .cmd      (cmd),
    .beat_nxt (beat_nxt),
    .act_q    (burst_act),
    .dir_q    (burst_wr)
  );

  bseq_order u_order (
    .start (start_q),
    .beat  (beat_nxt),
    .mode  (mode),
    .ofs   (ofs)
  );

  bseq_addr #(.ADDR_W(ADDR_W)) u_addr (
    .clk       (clk),
    .rst       (rst),
    .cmd       (cmd),
    .base_addr (base_addr),
    .ofs       (ofs),
    .start_q   (start_q),
    .word_q    (word_addr)
  );

endmodule

// File: rtl/bseq_checks.sv
module bseq_checks #(
  parameter int unsigned ADDR_W = 16
) (
  input logic              clk,
  input logic              rst,
  input logic              clk_en,
  input logic              step,
  input logic              sel,
  input logic              wr_dir,
  input logic              interleave,
  input logic [ADDR_W-1:0] base_addr,
  input logic [ADDR_W-1:0] word_addr,
  input logic              burst_wr,
  input logic              burst_act
);

  a_r1_reset: assert property (@(posedge clk)
    rst |=> (!burst_act && !burst_wr && word_addr == '0));

  a_r2_load: assert property (@(posedge clk) disable iff (rst)
    (clk_en && !step && sel) |=>
      (burst_act && word_addr == $past(base_addr) && burst_wr == $past(wr_dir)));

  a_r3_linear_step: assert property (@(posedge clk) disable iff (rst)
    (clk_en && step && burst_act && !interleave) |=>
      (word_addr[1:0] == 2'($past(word_addr[1:0]) + 2'd1)));

  a_r5_upper_fixed: assert property (@(posedge clk) disable iff (rst)
    (clk_en && step) |=> (word_addr[ADDR_W-1:2] == $past(word_addr[ADDR_W-1:2])));

  a_r7_dir_kept: assert property (@(posedge clk) disable iff (rst)
    (clk_en && step) |=> $stable(burst_wr));

  a_r8_freeze: assert property (@(posedge clk) disable iff (rst)
    !clk_en |=> ($stable(word_addr) && $stable(burst_wr) && $stable(burst_act)));

  a_r9_deselect: assert property (@(posedge clk) disable iff (rst)
    (clk_en && !step && !sel) |=> (!burst_act && $stable(word_addr)));

  a_r9_idle_stays: assert property (@(posedge clk) disable iff (rst)
    (clk_en && step && !burst_act) |=> (!burst_act && $stable(word_addr)));

endmodule

bind bseq_top bseq_checks #(.ADDR_W(ADDR_W)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .clk_en     (clk_en),
  .step       (step),
  .sel        (sel),
  .wr_dir     (wr_dir),
  .interleave (interleave),
  .base_addr  (base_addr),
  .word_addr  (word_addr),
  .burst_wr   (burst_wr),
  .burst_act  (burst_act)
);

// File: tb/bseq_top_tb.sv
module bseq_top_tb;

  localparam int AW = 6;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          clk_en = 1'b0;
  logic          step = 1'b0;
  logic          sel = 1'b0;
  logic          wr_dir = 1'b0;
  logic          interleave = 1'b0;
  logic [AW-1:0] base_addr = '0;
  logic [AW-1:0] word_addr;
  logic          burst_wr;
  logic          burst_act;

  int  n_vec = 0;
  int  n_bad = 0;
  bit  done  = 1'b0;

  always #5 clk = ~clk;

  bseq_top #(.ADDR_W(AW)) u_dut (
    .clk        (clk),
    .rst        (rst),
    .clk_en     (clk_en),
    .step       (step),
    .sel        (sel),
    .wr_dir     (wr_dir),
    .interleave (interleave),
    .base_addr  (base_addr),
    .word_addr  (word_addr),
    .burst_wr   (burst_wr),
    .burst_act  (burst_act)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_vec++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // Drive one cycle at the falling edge, let the rising edge act, and return
  // at the next falling edge, where outputs are stable for checking.
  task automatic tick(input logic en, input logic st, input logic cs,
                      input logic wd, input logic [AW-1:0] a);
    clk_en    = en;
    step      = st;
    sel       = cs;
    wr_dir    = wd;
    base_addr = a;
    @(posedge clk);
    @(negedge clk);
  endtask

  function automatic int exp_ofs(input int s, input int n, input bit ilv);
    return ilv ? ((s ^ (n % 4)) & 3) : ((s + n) % 4);
  endfunction

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      summary();
    end
  end

  initial begin
    int hold_addr;
    int exp_addr;
    @(negedge clk);
    tick(1'b1, 1'b0, 1'b1, 1'b1, 6'd37);
    tick(1'b1, 1'b0, 1'b1, 1'b1, 6'd37);
    chk("R1 addr", int'(word_addr), 0);
    chk("R1 act", int'(burst_act), 0);
    chk("R1 wr", int'(burst_wr), 0);
    rst = 1'b0;

    // Exhaustive sweep: both orders, every base address, nine beats.
    for (int m = 0; m < 2; m++) begin
      interleave = m[0];
      for (int b = 0; b < 64; b++) begin
        bit wd0;
        wd0 = b[0] ^ m[0] ^ b[3];
        tick(1'b1, 1'b0, 1'b1, wd0, AW'(b));
        chk("R2 addr", int'(word_addr), b);
        chk("R2 act", int'(burst_act), 1);
        chk("R2 wr", int'(burst_wr), int'(wd0));
        for (int n = 1; n <= 9; n++) begin
          if (n % 3 == 0) begin
            hold_addr = int'(word_addr);
            tick(1'b0, 1'b0, 1'b0, ~wd0, AW'(~b));
            chk("R8 addr", int'(word_addr), hold_addr);
            chk("R8 act", int'(burst_act), 1);
            chk("R8 wr", int'(burst_wr), int'(wd0));
          end
          tick(1'b1, 1'b1, n[0], ~wd0, AW'(~b));
          exp_addr = (b & ~3) | exp_ofs(b & 3, n, m[0]);
          if (n >= 4)
            chk(m[0] ? "R6 R4 wrap" : "R6 R3 wrap", int'(word_addr), exp_addr);
          else
            chk(m[0] ? "R4 order" : "R3 order", int'(word_addr), exp_addr);
          chk("R5 upper", int'(word_addr) >> 2, b >> 2);
          chk("R7 wr", int'(burst_wr), int'(wd0));
        end
      end
    end

    // Deselect, then advance while idle.
    interleave = 1'b0;
    tick(1'b1, 1'b0, 1'b1, 1'b1, 6'd22);
    tick(1'b1, 1'b1, 1'b0, 1'b0, 6'd0);
    hold_addr = int'(word_addr);
    tick(1'b1, 1'b0, 1'b0, 1'b0, 6'd9);
    chk("R9 deselect act", int'(burst_act), 0);
    chk("R9 deselect addr", int'(word_addr), hold_addr);
    for (int k = 0; k < 3; k++) begin
      tick(1'b1, 1'b1, 1'b1, 1'b0, 6'd9);
      chk("R9 idle act", int'(burst_act), 0);
      chk("R9 idle addr", int'(word_addr), hold_addr);
    end

    // Reload during a burst: base 5 linear, then base 41 interleaved.
    tick(1'b1, 1'b0, 1'b1, 1'b0, 6'd5);
    tick(1'b1, 1'b1, 1'b1, 1'b0, 6'd0);
    chk("R10 first burst", int'(word_addr), 6);
    interleave = 1'b1;
    tick(1'b1, 1'b0, 1'b1, 1'b1, 6'd41);
    chk("R10 reload addr", int'(word_addr), 41);
    chk("R10 reload wr", int'(burst_wr), 1);
    tick(1'b1, 1'b1, 1'b0, 1'b0, 6'd0);
    chk("R10 new sequence", int'(word_addr), 40);

    // Reset in the middle of a burst, with clk_en low.
    rst = 1'b1;
    tick(1'b0, 1'b1, 1'b1, 1'b1, 6'd63);
    rst = 1'b0;
    chk("R1 mid addr", int'(word_addr), 0);
    chk("R1 mid act", int'(burst_act), 0);
    chk("R1 mid wr", int'(burst_wr), 0);

    done = 1'b1;
    summary();
  end

endmodule